// File: doc/BRIEF.md
# Deconvolution Output Position Converter

In an input-oriented transposed-convolution engine, each activation is multiplied by one kernel weight. The product must be placed in the output map at the position the stride and the kernel offset give. This block takes the index of the activation handled by the first processing element (PE) of a row, together with the kernel index of the weight the row currently shares. It returns the output coordinate of every PE's product on the depth, row and column axes. It also tells each PE where its product must go: either to the local result path, or to the overlap path that feeds one neighbour, where the product waits to be summed with that neighbour's product for the same output element.

The stride is held in a small register written by a configuration strobe. One multiplier per axis produces the coordinate of the first PE. The other PEs along the row step from it by adding the stride. In two-dimensional mode the depth axis is switched off. All results are registered and appear one cycle after the input strobe.

Top module: `deconv_pos_conv`

## Requirements
- R1: While the block is in reset, and after it leaves reset, `out_valid` is 0, `out_d`, `out_r` and every `out_c` lane are 0, every route code is 0, and the stride register holds 1.
- R2: A cycle with `cfg_we` high loads `cfg_stride` into the stride register only when the value is 1 or 2. Any other value leaves the register unchanged. An input accepted in the same cycle as a write uses the old stride.
- R3: The column coordinate of PE 0 (bits CW-1:0 of `out_c`) equals `act_c * S + wt_c`, taken modulo 2^CW (CW = 10).
- R4: For each PE j ≥ 1, lane j of `out_c` (bits j*CW +: CW) equals lane j−1 plus S, modulo 2^CW.
- R5: In three-dimensional mode (`in_3d` = 1), `out_r` = `act_r * S + wt_r` and `out_d` = `act_d * S + wt_d`, both modulo 2^CW. Both values are shared by every PE of the row.
- R6: In two-dimensional mode (`in_3d` = 0), `out_d` is 0, route code 3 is never produced, and `act_d`, `wt_d` and `in_last_plane` have no effect on any output.
- R7: The 2-bit route code of PE j (bits 2j+1:2j of `out_route`) is chosen by priority. Code 1 (send to the next PE in the row) applies when j < NPE−1 and `wt_c` ≥ S. Otherwise code 2 (send to the next row) applies when `wt_r` ≥ S and `in_last_row` = 0. Otherwise code 3 (send to the next plane) applies when the mode is 3D, `wt_d` ≥ S and `in_last_plane` = 0. Otherwise code 0 (local result path) applies.
- R8: `out_valid` is high in exactly the cycle after each cycle with `in_valid` high. In a cycle with `in_valid` low, the coordinates and route codes keep their values, whatever the other inputs or stride writes do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Stride write strobe |
| cfg_stride | input | SW (2) | Stride value to load |
| in_valid | input | 1 | Input strobe |
| in_3d | input | 1 | 1 = three-dimensional mode, 0 = two-dimensional mode |
| in_last_row | input | 1 | Activation row has no following row in the tile |
| in_last_plane | input | 1 | Activation plane has no following plane in the tile |
| act_d | input | CW (10) | Depth index of the first PE's activation |
| act_r | input | CW (10) | Row index of the first PE's activation |
| act_c | input | CW (10) | Column index of the first PE's activation |
| wt_d | input | KW (2) | Kernel depth index, below K |
| wt_r | input | KW (2) | Kernel row index, below K |
| wt_c | input | KW (2) | Kernel column index, below K |
| out_valid | output | 1 | Results valid |
| out_d | output | CW (10) | Output depth coordinate |
| out_r | output | CW (10) | Output row coordinate |
| out_c | output | NPE*CW (40) | Output column coordinate per PE, lane j at j*CW |
| out_route | output | 2*NPE (8) | Route code per PE, lane j at 2j |

## Verification
Assertions check on every cycle that the output strobe follows the input strobe one cycle later, and that column lanes step by exactly the stride that was in force when the input was taken. They also check the first column and row coordinates against the registered inputs, that the stride register never holds an illegal value, that 2D inputs give a zero depth coordinate and no plane route, that weights below the stride route everything locally, and that held outputs stay stable. The bench scenarios are needed for the rest: routing priority when several axes overlap at once, the missing column route on the last PE, modulo wrap at the coordinate limit, rejected stride writes seen through the lane spacing, the default stride after reset, and proof that the depth inputs are ignored in 2D mode.

// File: rtl/deconv_pos_pkg.sv
`timescale 1ns/1ps
package deconv_pos_pkg;
  typedef enum logic [1:0] {
    RT_LOCAL      = 2'd0,
    RT_NEXT_PE    = 2'd1,
    RT_NEXT_ROW   = 2'd2,
    RT_NEXT_PLANE = 2'd3
  } route_t;
endpackage

// File: rtl/deconv_axis_base.sv
`timescale 1ns/1ps
// First-PE coordinate on one axis: the only multiplier on that axis.
module deconv_axis_base #(
  parameter int CW = 10,
  parameter int KW = 2,
  parameter int SW = 2
) (
  input  logic [CW-1:0] act,
  input  logic [KW-1:0] wt,
  input  logic [SW-1:0] stride,
  output logic [CW-1:0] coord
);
  logic [CW-1:0] prod;

  always_comb begin
    prod  = act * CW'(stride);
    coord = prod + CW'(wt);
  end
endmodule

// File: rtl/deconv_col_chain.sv
`timescale 1ns/1ps
// Neighbouring column coordinates: one adder per PE, no further multipliers.
module deconv_col_chain #(
  parameter int NPE = 4,
  parameter int CW  = 10,
  parameter int SW  = 2
) (
  input  logic [CW-1:0]           base,
  input  logic [SW-1:0]           stride,
  output logic [NPE-1:0][CW-1:0]  coord
);
  for (genvar j = 0; j < NPE; j++) begin : g_st
    logic [CW-1:0] val;
    if (j == 0) begin : g_first
      assign val = base;
    end else begin : g_next
      assign val = g_st[j-1].val + CW'(stride);
    end
    assign coord[j] = val;
  end
endmodule

// File: rtl/deconv_route_class.sv
`timescale 1ns/1ps
// Overlap classification per PE, with a fixed priority column > row > plane.
module deconv_route_class
  import deconv_pos_pkg::*;
#(
  parameter int NPE = 4,
  parameter int KW  = 2,
  parameter int SW  = 2
) (
  input  logic [SW-1:0]          stride,
  input  logic                   is3d,
  input  logic                   last_row,
  input  logic                   last_plane,
  input  logic [KW-1:0]          wt_d,
  input  logic [KW-1:0]          wt_r,
  input  logic [KW-1:0]          wt_c,
  output logic [NPE-1:0][1:0]    route
);
  localparam int MW = (KW > SW) ? KW : SW;

  logic col_ovl, row_ovl, pln_ovl;

  always_comb begin
    col_ovl = MW'(wt_c) >= MW'(stride);
    row_ovl = (MW'(wt_r) >= MW'(stride)) && !last_row;
    pln_ovl = is3d && (MW'(wt_d) >= MW'(stride)) && !last_plane;
  end

  for (genvar j = 0; j < NPE; j++) begin : g_pe
    localparam bit HAS_NEXT = (j < NPE - 1);
    route_t rt;
    always_comb begin
      if (HAS_NEXT && col_ovl)  rt = RT_NEXT_PE;
      else if (row_ovl)         rt = RT_NEXT_ROW;
      else if (pln_ovl)         rt = RT_NEXT_PLANE;
      else                      rt = RT_LOCAL;
    end
    assign route[j] = rt;
  end
endmodule

// File: rtl/deconv_pos_conv.sv
`timescale 1ns/1ps
module deconv_pos_conv
  import deconv_pos_pkg::*;
#(
  parameter int NPE = 4,
  parameter int CW  = 10,
  parameter int K   = 3,
  parameter int SW  = 2,
  localparam int KW = (K > 2) ? $clog2(K) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [SW-1:0]        cfg_stride,
  input  logic                 in_valid,
  input  logic                 in_3d,
  input  logic                 in_last_row,
  input  logic                 in_last_plane,
  input  logic [CW-1:0]        act_d,
  input  logic [CW-1:0]        act_r,
  input  logic [CW-1:0]        act_c,
  input  logic [KW-1:0]        wt_d,
  input  logic [KW-1:0]        wt_r,
  input  logic [KW-1:0]        wt_c,
  output logic                 out_valid,
  output logic [CW-1:0]        out_d,
  output logic [CW-1:0]        out_r,
  output logic [NPE*CW-1:0]    out_c,
  output logic [2*NPE-1:0]     out_route
);
  // reset: asserted asynchronously, released after two clock edges
  logic rs_meta, rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta <= 1'b0;
      rst_q   <= 1'b0;
    end else begin
      rs_meta <= 1'b1;
      rst_q   <= rs_meta;
    end
  end

  // stride register
  logic [SW-1:0] stride_q, stride_nxt;
  logic          stride_legal;
  always_comb begin
    stride_legal = (cfg_stride == SW'(1)) || (cfg_stride == SW'(2));
    stride_nxt   = stride_q;
    if (cfg_we && stride_legal) stride_nxt = cfg_stride;
  end
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) stride_q <= SW'(1);
    else        stride_q <= stride_nxt;
  end

  // datapath
  logic [CW-1:0]          base_d, base_r, base_c;
  logic [NPE-1:0][CW-1:0] col_calc;
  logic [NPE-1:0][1:0]    route_calc;

  deconv_axis_base #(.CW(CW), .KW(KW), .SW(SW)) u_ax_d (
    .act(act_d), .wt(wt_d), .stride(stride_q), .coord(base_d));
  deconv_axis_base #(.CW(CW), .KW(KW), .SW(SW)) u_ax_r (
    .act(act_r), .wt(wt_r), .stride(stride_q), .coord(base_r));
  deconv_axis_base #(.CW(CW), .KW(KW), .SW(SW)) u_ax_c (
    .act(act_c), .wt(wt_c), .stride(stride_q), .coord(base_c));

  deconv_col_chain #(.NPE(NPE), .CW(CW), .SW(SW)) u_chain (
    .base(base_c), .stride(stride_q), .coord(col_calc));

  deconv_route_class #(.NPE(NPE), .KW(KW), .SW(SW)) u_route (
    .stride(stride_q), .is3d(in_3d), .last_row(in_last_row),
    .last_plane(in_last_plane), .wt_d(wt_d), .wt_r(wt_r), .wt_c(wt_c),
    .route(route_calc));

  // output registers, clock-enabled by in_valid
  logic                   vld_q;
  logic [CW-1:0]          d_q, d_nxt, r_q, r_nxt;
  logic [NPE-1:0][CW-1:0] c_q, c_nxt;
  logic [NPE-1:0][1:0]    rt_q, rt_nxt;

  always_comb begin
    d_nxt  = d_q;
    r_nxt  = r_q;
    c_nxt  = c_q;
    rt_nxt = rt_q;
    if (in_valid) begin
      d_nxt  = in_3d ? base_d : '0;
      r_nxt  = base_r;
      c_nxt  = col_calc;
      rt_nxt = route_calc;
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      vld_q <= 1'b0;
      d_q   <= '0;
      r_q   <= '0;
      c_q   <= '0;
      rt_q  <= '0;
    end else begin
      vld_q <= in_valid;
      d_q   <= d_nxt;
      r_q   <= r_nxt;
      c_q   <= c_nxt;
      rt_q  <= rt_nxt;
    end
  end

  assign out_valid = vld_q;
  assign out_d     = d_q;
  assign out_r     = r_q;
  assign out_c     = c_q;
  assign out_route = rt_q;

  // ---------------- assertions ----------------
  assert_stride_legal_R2: assert property (@(posedge clk) disable iff (!rst_q)
    (stride_q == SW'(1)) || (stride_q == SW'(2)));

  assert_wt_range_R3: assert property (@(posedge clk) disable iff (!rst_q)
    in_valid |-> (int'(wt_c) < K) && (int'(wt_r) < K) && (int'(wt_d) < K));

  assert_first_col_R3: assert property (@(posedge clk) disable iff (!rst_q)
    in_valid |=> out_c[CW-1:0] ==
      CW'($past(act_c) * CW'($past(stride_q)) + CW'($past(wt_c))));

  assert_row_coord_R5: assert property (@(posedge clk) disable iff (!rst_q)
    in_valid |=> out_r ==
      CW'($past(act_r) * CW'($past(stride_q)) + CW'($past(wt_r))));

  assert_2d_depth_R6: assert property (@(posedge clk) disable iff (!rst_q)
    in_valid && !in_3d |=> out_d == '0);

  assert_valid_rise_R8: assert property (@(posedge clk) disable iff (!rst_q)
    in_valid |=> out_valid);

  assert_valid_fall_R8: assert property (@(posedge clk) disable iff (!rst_q)
    !in_valid |=> !out_valid);

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_q)
    !in_valid |=> $stable(out_c) && $stable(out_d) && $stable(out_r) && $stable(out_route));

  for (genvar j = 0; j < NPE; j++) begin : g_chk
    if (j > 0) begin : g_step
      assert_chain_step_R4: assert property (@(posedge clk) disable iff (!rst_q)
        in_valid |=> CW'(out_c[j*CW +: CW] - out_c[(j-1)*CW +: CW]) ==
                     CW'($past(stride_q)));
    end
    assert_no_plane_2d_R6: assert property (@(posedge clk) disable iff (!rst_q)
      in_valid && !in_3d |=> out_route[2*j +: 2] != 2'd3);
    assert_local_R7: assert property (@(posedge clk) disable iff (!rst_q)
      in_valid && (wt_c < KW'(stride_q)) && (wt_r < KW'(stride_q)) &&
      (!in_3d || (wt_d < KW'(stride_q))) |=> out_route[2*j +: 2] == 2'd0);
  end
endmodule

// File: tb/sim_deconv_pos_conv.sv
`timescale 1ns/1ps
module sim_deconv_pos_conv;
  localparam int NPE = 4;
  localparam int CW  = 10;
  localparam int KW  = 2;
  localparam int NV  = 8;
  localparam int VW  = 41;
  // {stride, 3d, last_row, last_plane, act_d, act_r, act_c, wt_d, wt_r, wt_c}
  localparam logic [VW-1:0] VEC [NV] = '{
    {2'd1, 1'b1, 1'b0, 1'b0, 10'd3,   10'd5, 10'd7,    2'd0, 2'd1, 2'd2},
    {2'd2, 1'b1, 1'b0, 1'b0, 10'd2,   10'd4, 10'd6,    2'd2, 2'd1, 2'd0},
    {2'd2, 1'b0, 1'b0, 1'b0, 10'd2,   10'd4, 10'd6,    2'd2, 2'd1, 2'd0},
    {2'd2, 1'b1, 1'b1, 1'b0, 10'd9,   10'd8, 10'd1,    2'd0, 2'd2, 2'd1},
    {2'd2, 1'b1, 1'b0, 1'b0, 10'd0,   10'd1, 10'd1020, 2'd1, 2'd0, 2'd2},
    {2'd1, 1'b0, 1'b0, 1'b0, 10'd40,  10'd3, 10'd12,   2'd2, 2'd2, 2'd0},
    {2'd1, 1'b1, 1'b1, 1'b1, 10'd6,   10'd6, 10'd6,    2'd1, 2'd1, 2'd0},
    {2'd2, 1'b1, 1'b0, 1'b0, 10'd511, 10'd0, 10'd0,    2'd0, 2'd0, 2'd0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_stride = '0;
  logic in_valid = 1'b0, in_3d = 1'b0, in_last_row = 1'b0, in_last_plane = 1'b0;
  logic [CW-1:0] act_d = '0, act_r = '0, act_c = '0;
  logic [KW-1:0] wt_d = '0, wt_r = '0, wt_c = '0;
  logic out_valid;
  logic [CW-1:0] out_d, out_r;
  logic [NPE*CW-1:0] out_c;
  logic [2*NPE-1:0] out_route;

  int checks = 0;
  int fails  = 0;
  int cur_s  = 1;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  deconv_pos_conv u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_stride(cfg_stride),
    .in_valid(in_valid), .in_3d(in_3d), .in_last_row(in_last_row),
    .in_last_plane(in_last_plane), .act_d(act_d), .act_r(act_r), .act_c(act_c),
    .wt_d(wt_d), .wt_r(wt_r), .wt_c(wt_c), .out_valid(out_valid),
    .out_d(out_d), .out_r(out_r), .out_c(out_c), .out_route(out_route));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int model_route(input int j, input int s, input bit m,
      input bit lr, input bit lp, input int wd, input int wr, input int wc);
    if (j < NPE - 1 && wc >= s)   return 1;
    if (wr >= s && !lr)           return 2;
    if (m && wd >= s && !lp)      return 3;
    return 0;
  endfunction

  task automatic write_stride(input int v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_stride = 2'(v);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic drive(input logic [VW-1:0] v);
    in_3d = v[38]; in_last_row = v[37]; in_last_plane = v[36];
    act_d = v[35:26]; act_r = v[25:16]; act_c = v[15:6];
    wt_d = v[5:4]; wt_r = v[3:2]; wt_c = v[1:0];
  endtask

  // apply one vector with stride s and compare every output field
  task automatic run_vec(input logic [VW-1:0] v, input int s);
    int base;
    @(negedge clk);
    drive(v);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R8 out_valid", int'(out_valid), 1);
    base = int'(v[15:6]) * s + int'(v[1:0]);
    for (int j = 0; j < NPE; j++) begin
      chk(j == 0 ? "R3 first column" : "R4 column step",
          int'(out_c[j*CW +: CW]), (base + j * s) % 1024);
      chk("R7 route", int'(out_route[2*j +: 2]),
          model_route(j, s, v[38], v[37], v[36], int'(v[5:4]), int'(v[3:2]), int'(v[1:0])));
    end
    chk("R5 row", int'(out_r), (int'(v[25:16]) * s + int'(v[3:2])) % 1024);
    if (v[38]) chk("R5 depth", int'(out_d), (int'(v[35:26]) * s + int'(v[5:4])) % 1024);
    else       chk("R6 depth zero in 2D", int'(out_d), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [CW-1:0] hc0;
    logic [2*NPE-1:0] hrt;
    logic [CW-1:0] hd;
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 valid in reset", int'(out_valid), 0);
    chk("R1 column in reset", int'(out_c), 0);
    chk("R1 route in reset", int'(out_route), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 valid after reset", int'(out_valid), 0);
    chk("R1 row after reset", int'(out_r), 0);
    chk("R1 depth after reset", int'(out_d), 0);

    // table walk; first vector uses the reset stride of 1 (R1)
    for (int i = 0; i < NV; i++) begin
      int s;
      s = int'(VEC[i][40:39]);
      if (s != cur_s) begin
        write_stride(s);
        cur_s = s;
      end
      run_vec(VEC[i], s);
    end

    // R2: illegal writes are dropped, stride stays 2
    write_stride(3);
    write_stride(0);
    run_vec(VEC[1], 2);
    // R2: write in the same cycle as an input uses the old stride
    @(negedge clk);
    drive(VEC[0]);
    in_valid = 1'b1; cfg_we = 1'b1; cfg_stride = 2'd1;
    @(negedge clk);
    in_valid = 1'b0; cfg_we = 1'b0;
    chk("R2 old stride on same-cycle write",
        int'(CW'(out_c[2*CW +: CW] - out_c[CW +: CW])), 2);
    cur_s = 1;
    run_vec(VEC[0], 1);

    // R6: depth inputs have no effect in 2D mode
    run_vec({2'd1, 1'b0, 1'b0, 1'b0, 10'd77, 10'd3, 10'd4, 2'd2, 2'd0, 2'd0}, 1);
    hc0 = out_c[CW-1:0]; hrt = out_route; hd = out_d;
    run_vec({2'd1, 1'b0, 1'b0, 1'b1, 10'd900, 10'd3, 10'd4, 2'd0, 2'd0, 2'd0}, 1);
    chk("R6 column unchanged by depth inputs", int'(out_c[CW-1:0]), int'(hc0));
    chk("R6 route unchanged by depth inputs", int'(out_route), int'(hrt));
    chk("R6 depth unchanged", int'(out_d), int'(hd));

    // R8: outputs held while in_valid low, despite input and stride changes
    hc0 = out_c[CW-1:0]; hrt = out_route;
    @(negedge clk);
    act_c = 10'd500; wt_c = 2'd2; cfg_we = 1'b1; cfg_stride = 2'd2;
    @(negedge clk);
    cfg_we = 1'b0;
    chk("R8 valid low when idle", int'(out_valid), 0);
    chk("R8 column held", int'(out_c[CW-1:0]), int'(hc0));
    chk("R8 route held", int'(out_route), int'(hrt));

    // R8: back-to-back inputs each appear one cycle later
    @(negedge clk);
    drive(VEC[1]); in_valid = 1'b1;
    @(negedge clk);
    chk("R8 first of pair", int'(out_c[CW-1:0]), 6 * 2 + 0);
    drive(VEC[3]);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R8 second of pair", int'(out_c[CW-1:0]), 1 * 2 + 1);
    chk("R8 valid on second", int'(out_valid), 1);
    @(negedge clk);
    chk("R8 valid drops", int'(out_valid), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule